// File: doc/BRIEF.md
# Programmable One-Shot / Periodic Countdown Timer

This block is a single countdown timer reached through a simple 32-bit register bus, with one level-sensitive interrupt line. Software programs an interval and then launches a countdown through one of two start registers. One launches a single run and the other launches a run that repeats. The counter moves down by one on each clock cycle in which the tick-enable input is high. When it expires, a pending flag is raised and drives the interrupt.

A single run drops the active flag when it expires. A repeating run reloads the interval and keeps going. Halting the countdown and acknowledging the interrupt are separate writes, so software can do either one without the other. A status register reports both flags. Command registers act only on nonzero data, so a write of zero to them does nothing.

The bus is write-strobed with a byte address. Read data is combinational from the address and the current state. The interval register is `CNT_W` bits wide and is zero-extended when read back.

Top module: `cdtimer`

## Requirements
- R1: After reset, the status register (offset 0x00) and the interval register (offset 0x0C) read zero, and `irq_o` is low.
- R2: A read of offset 0x00 returns the active flag in bit 0 and the pending flag in bit 1, with all other bits zero. A read of 0x0C returns the interval.
- R3: A nonzero write to offset 0x04 clears the active flag in the next cycle and leaves the pending flag unchanged.
- R4: A nonzero write to offset 0x08 clears the pending flag in the next cycle and leaves the active flag unchanged.
- R5: A nonzero write to offset 0x10 loads the counter from the interval and sets the active flag. The N-th tick after that (N = interval) makes the run expire. In the cycle after that tick, active reads 0 and pending reads 1.
- R6: A nonzero write to offset 0x14 starts a repeating run. Pending is raised every N ticks, the counter reloads from the interval register, and active stays set.
- R7: Writes of zero to offsets 0x04, 0x08, 0x10 and 0x14 change nothing.
- R8: A run started with an interval of zero expires on its first tick.
- R9: Cycles with `tick_en_i` low do not move the counter.
- R10: `irq_o` always equals the pending flag.
- R11: If an expiry and an acknowledge happen in the same cycle, pending ends up set. If a halt and the final tick happen in the same cycle, there is no expiry.
- R12: Writes to any other offset are ignored. Reads of any offset other than 0x00 and 0x0C return zero.
- R13: A write to 0x0C keeps only the low `CNT_W` bits of the data, and it takes effect at the next start or reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | Count-enable; one decrement per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address of the access |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i` |
| irq_o | output | 1 | Level interrupt, high while pending |

## Verification
The bench builds the timer with `CNT_W` set to 4 and `DATA_W`/`ADDR_W` left at their defaults of 32 and 8. The narrow counter makes the interval truncation of R13 visible: a write of 0x13 becomes an interval of 3. It also keeps every run short enough that single runs, repeating runs, reloads, a zero interval, halts that coincide with the last tick, and acknowledges that coincide with an expiry all fit into a few hundred cycles. The bench compares each of these against its reference model on every clock. The `CNT_W == DATA_W` branch of the readback zero-extension is covered only by elaboration with the defaults.

// File: rtl/cdtimer_pkg.sv
package cdtimer_pkg;
   localparam int unsigned OFF_STATUS = 'h00;
   localparam int unsigned OFF_HALT   = 'h04;
   localparam int unsigned OFF_ACK    = 'h08;
   localparam int unsigned OFF_INTV   = 'h0C;
   localparam int unsigned OFF_ONCE   = 'h10;
   localparam int unsigned OFF_LOOP   = 'h14;

   typedef struct packed {
      logic halt;
      logic ack;
      logic load;
      logic go_once;
      logic go_loop;
   } tmr_cmd_t;
endpackage

// File: rtl/cdtimer_decode.sv
module cdtimer_decode
   import cdtimer_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8
) (
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output tmr_cmd_t          cmd_o
);
   logic nonzero;
   logic hit_halt, hit_ack, hit_intv, hit_once, hit_loop;

   always_comb begin
      nonzero  = |wdata_i;
      hit_halt = (addr_i == ADDR_W'(OFF_HALT));
      hit_ack  = (addr_i == ADDR_W'(OFF_ACK));
      hit_intv = (addr_i == ADDR_W'(OFF_INTV));
      hit_once = (addr_i == ADDR_W'(OFF_ONCE));
      hit_loop = (addr_i == ADDR_W'(OFF_LOOP));
      cmd_o.halt    = wr_en_i && hit_halt && nonzero;
      cmd_o.ack     = wr_en_i && hit_ack  && nonzero;
      cmd_o.load    = wr_en_i && hit_intv;
      cmd_o.go_once = wr_en_i && hit_once && nonzero;
      cmd_o.go_loop = wr_en_i && hit_loop && nonzero;
   end
endmodule

// File: rtl/cdtimer_regs.sv
module cdtimer_regs
   import cdtimer_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8,
   parameter int CNT_W  = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  tmr_cmd_t          cmd_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              active_i,
   input  logic              pending_i,
   output logic [CNT_W-1:0]  interval_o,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int PAD_W = DATA_W - CNT_W;

   logic [CNT_W-1:0]  interval_q;
   logic [DATA_W-1:0] intv_ext;
   logic [DATA_W-1:0] status_ext;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          interval_q <= '0;
      else if (cmd_i.load)  interval_q <= wdata_i[CNT_W-1:0];
   end

   generate
      if (PAD_W == 0) begin : g_full
         assign intv_ext = interval_q;
      end else begin : g_pad
         assign intv_ext = {{PAD_W{1'b0}}, interval_q};
      end
   endgenerate

   assign status_ext = {{(DATA_W-2){1'b0}}, pending_i, active_i};

   always_comb begin
      if (addr_i == ADDR_W'(OFF_STATUS))    rdata_o = status_ext;
      else if (addr_i == ADDR_W'(OFF_INTV)) rdata_o = intv_ext;
      else                                  rdata_o = '0;
   end

   assign interval_o = interval_q;

   AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_i.load |=> interval_o == $past(wdata_i[CNT_W-1:0]));   // R13
endmodule

// File: rtl/cdtimer_core.sv
module cdtimer_core
   import cdtimer_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_en_i,
   input  tmr_cmd_t         cmd_i,
   input  logic [CNT_W-1:0] interval_i,
   output logic             active_o,
   output logic             pending_o
);
   logic             active_q, pending_q, periodic_q;
   logic [CNT_W-1:0] count_q;
   logic             start, last, expire;

   always_comb begin
      start  = cmd_i.go_once || cmd_i.go_loop;
      last   = (count_q <= CNT_W'(1));
      expire = active_q && tick_en_i && !start && !cmd_i.halt && last;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         active_q   <= 1'b0;
         periodic_q <= 1'b0;
         count_q    <= '0;
      end else if (start) begin
         active_q   <= 1'b1;
         periodic_q <= cmd_i.go_loop;
         count_q    <= interval_i;
      end else if (cmd_i.halt) begin
         active_q   <= 1'b0;
      end else if (active_q && tick_en_i) begin
         if (last) begin
            if (periodic_q) count_q  <= interval_i;
            else            active_q <= 1'b0;
         end else begin
            count_q <= count_q - CNT_W'(1);
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          pending_q <= 1'b0;
      else if (expire)      pending_q <= 1'b1;
      else if (cmd_i.ack)   pending_q <= 1'b0;
   end

   assign active_o  = active_q;
   assign pending_o = pending_q;

   AST_HALT_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_i.halt && !start |=> !active_o);   // R3
   AST_HALT_KEEPS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_i.halt && !cmd_i.ack |=> pending_o == $past(pending_o));   // R3
   AST_ACK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_i.ack && !active_o |=> !pending_o);   // R4
   AST_START_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start |=> active_o);   // R5
   AST_ONCE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire && !periodic_q |=> !active_o && pending_o);   // R5
   AST_LOOP_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire && periodic_q |=> active_o && pending_o);   // R6
   AST_NO_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_en_i && !start && !cmd_i.halt && !cmd_i.ack
      |=> $stable(active_o) && $stable(pending_o) && $stable(count_q));   // R9
   AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire && cmd_i.ack |=> pending_o);   // R11
endmodule

// File: rtl/cdtimer.sv
module cdtimer
   import cdtimer_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8,
   parameter int CNT_W  = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_en_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              irq_o
);
   generate
      if (DATA_W < 8)                   begin : g_bad_data $error("DATA_W must be at least 8"); end
      if (ADDR_W < 5)                   begin : g_bad_addr $error("ADDR_W must reach offset 0x14"); end
      if (CNT_W < 1 || CNT_W > DATA_W)  begin : g_bad_cnt  $error("CNT_W must lie in 1..DATA_W"); end
   endgenerate

   tmr_cmd_t         cmd;
   logic [CNT_W-1:0] interval;
   logic             active, pending;

   cdtimer_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_decode (
      .wr_en_i (wr_en_i),
      .addr_i  (addr_i),
      .wdata_i (wdata_i),
      .cmd_o   (cmd)
   );

   cdtimer_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cmd_i      (cmd),
      .addr_i     (addr_i),
      .wdata_i    (wdata_i),
      .active_i   (active),
      .pending_i  (pending),
      .interval_o (interval),
      .rdata_o    (rdata_o)
   );

   cdtimer_core #(.CNT_W(CNT_W)) u_core (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_en_i  (tick_en_i),
      .cmd_i      (cmd),
      .interval_i (interval),
      .active_o   (active),
      .pending_o  (pending)
   );

   assign irq_o = pending;

   AST_IRQ_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o == rdata_o[1] || addr_i != ADDR_W'(OFF_STATUS));   // R10
endmodule

// File: tb/cdtimer_bench.sv
`timescale 1ns/1ps
module cdtimer_bench;
   localparam int CW = 4;
   localparam int unsigned MASK = (1 << CW) - 1;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        tick = 0;
   logic        wr = 0;
   logic [7:0]  addr = 0;
   logic [31:0] wdata = 0;
   logic [31:0] rdata;
   logic        irq;

   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 0;

   int unsigned m_int = 0, m_cnt = 0;
   bit          m_act = 0, m_pend = 0, m_per = 0;

   always #2 clk = ~clk;

   cdtimer #(.DATA_W(32), .ADDR_W(8), .CNT_W(CW)) u_cdtimer (
      .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick), .wr_en_i(wr),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
   );

   function automatic logic [31:0] model_read(input logic [7:0] a);
      if (a == 8'h00)      return {30'b0, m_pend, m_act};
      else if (a == 8'h0C) return m_int;
      else                 return 32'h0;
   endfunction

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d,
                       input logic tk, input string tag);
      bit start, halt, ack, ld, exp_now;
      wr = w; addr = a; wdata = d; tick = tk;
      #1;
      check(tag, rdata, model_read(a));
      check("R10", {31'b0, irq}, {31'b0, m_pend});
      @(posedge clk);
      start = w && (a == 8'h10 || a == 8'h14) && d != 0;
      halt  = w && a == 8'h04 && d != 0;
      ack   = w && a == 8'h08 && d != 0;
      ld    = w && a == 8'h0C;
      exp_now = 0;
      if (start) begin
         m_act = 1; m_per = (a == 8'h14); m_cnt = m_int;
      end else if (halt) begin
         m_act = 0;
      end else if (m_act && tk) begin
         if (m_cnt <= 1) begin
            exp_now = 1;
            if (m_per) m_cnt = m_int; else m_act = 0;
         end else m_cnt = m_cnt - 1;
      end
      if (ack) m_pend = 0;
      if (exp_now) m_pend = 1;
      if (ld) m_int = d & MASK;
      @(negedge clk);
      wr = 0; tick = 0;
   endtask

   task automatic rd(input logic [7:0] a, input logic tk, input string tag);
      step(1'b0, a, 32'h0, tk, tag);
   endtask

   task automatic wrt(input logic [7:0] a, input logic [31:0] d, input logic tk, input string tag);
      step(1'b1, a, d, tk, tag);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1;
      check("R1", rdata, 32'h0);
      check("R1", {31'b0, irq}, 32'h0);
      rst_n = 1;
      @(negedge clk);
      rd(8'h00, 0, "R1");
      rd(8'h0C, 0, "R1");

      // R13: truncation of the interval to CNT_W bits
      wrt(8'h0C, 32'h13, 0, "R13");
      rd(8'h0C, 0, "R13");

      // R5: single run with irregular ticks
      wrt(8'h10, 32'h1, 0, "R5");
      for (int i = 0; i < 8; i++) rd(8'h00, (i % 3) != 1, "R5");
      rd(8'h00, 1, "R2");

      // R4: acknowledge
      wrt(8'h08, 32'h4, 0, "R4");
      rd(8'h00, 0, "R4");

      // R6: repeating run, interval 2
      wrt(8'h0C, 32'h2, 0, "R6");
      wrt(8'h14, 32'h1, 1, "R6");
      for (int i = 0; i < 10; i++) begin
         if (i == 5) wrt(8'h08, 32'h1, 0, "R4");
         else        rd(8'h00, 1, "R6");
      end

      // R7: zero writes to command registers while running
      wrt(8'h04, 32'h0, 0, "R7");
      wrt(8'h08, 32'h0, 0, "R7");
      wrt(8'h10, 32'h0, 0, "R7");
      wrt(8'h14, 32'h0, 0, "R7");
      rd(8'h00, 0, "R7");

      // R13: new interval takes effect at reload
      wrt(8'h0C, 32'h1, 1, "R13");
      for (int i = 0; i < 6; i++) rd(8'h00, 1, "R13");

      // R11: acknowledge every cycle during expiries
      for (int i = 0; i < 6; i++) wrt(8'h08, 32'h1, 1, "R11");
      rd(8'h00, 0, "R11");

      // R3: halt keeps pending
      wrt(8'h04, 32'h1, 1, "R3");
      for (int i = 0; i < 4; i++) rd(8'h00, 1, "R3");
      wrt(8'h08, 32'h1, 0, "R4");

      // R8: zero interval
      wrt(8'h0C, 32'h0, 0, "R8");
      wrt(8'h10, 32'h5, 0, "R8");
      rd(8'h00, 0, "R8");
      rd(8'h00, 1, "R8");
      rd(8'h00, 0, "R8");
      wrt(8'h08, 32'h1, 0, "R4");

      // R9: no ticks, no progress
      wrt(8'h0C, 32'h3, 0, "R9");
      wrt(8'h10, 32'h1, 0, "R9");
      for (int i = 0; i < 6; i++) rd(8'h00, 0, "R9");
      for (int i = 0; i < 4; i++) rd(8'h00, 1, "R9");
      wrt(8'h08, 32'h1, 0, "R4");

      // R11: halt together with final tick
      wrt(8'h0C, 32'h2, 0, "R11");
      wrt(8'h10, 32'h1, 1, "R11");
      rd(8'h00, 1, "R11");
      wrt(8'h04, 32'h1, 1, "R11");
      rd(8'h00, 1, "R11");

      // R12: other offsets
      wrt(8'h18, 32'hFFFF, 0, "R12");
      wrt(8'h00, 32'h3, 0, "R12");
      wrt(8'h11, 32'h1, 0, "R12");
      wrt(8'h0D, 32'h7, 0, "R12");
      rd(8'h00, 1, "R12");
      rd(8'h0C, 0, "R12");
      rd(8'h14, 0, "R12");
      rd(8'h18, 0, "R12");

      // R6 again with restart over a running loop
      wrt(8'h0C, 32'hF, 0, "R6");
      wrt(8'h14, 32'h1, 1, "R6");
      for (int i = 0; i < 40; i++) rd(8'h00, (i % 4) != 0, "R6");
      wrt(8'h10, 32'h1, 1, "R5");
      for (int i = 0; i < 20; i++) rd(8'h00, 1, "R5");

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule